// File: doc/BRIEF.md
# Variable-Rate Serial Clock Generator

This block drives the serial clock of an SPI master and tells an external shift register when to sample and when to shift. A transfer is always `CYCLES` serial clock cycles long, which is 16 by default. Each transfer is split into `2*CYCLES` half-periods. At every level change of the serial clock, the block raises a one-cycle strobe. A leading edge gives a sample strobe and a trailing edge gives a shift strobe.

In fixed mode every half-period lasts the low divider plus one system clock cycles. In variable mode a pattern word chooses, for each half-period, either the low or the high divider. The word is read from the MSB down, so the rate can change within a single transfer.

The pattern, both dividers and the mode are captured when a start is accepted. They stay frozen until the transfer ends. A start that arrives during a transfer is dropped.

Top module: `spi_varclk_gen`

## Requirements
- R1: While `rst_ni` is low, `sclk_o`, `sample_o`, `shift_o`, `busy_o` and `done_o` are all 0.
- R2: A `start_i` seen with `busy_o` low sets `busy_o` at the next clock edge. The transfer then gives exactly 16 leading and 16 trailing serial clock edges.
- R3: When `var_en_i` is 0, every half-period lasts `div_word_i[15:0]`+1 system clock cycles, so `busy_o` stays high for 32*(`div_word_i[15:0]`+1) cycles.
- R4: When `var_en_i` and `master_i` are both 1, half-period h (0 to 31) reads pattern bit 31-h. A 0 gives length `div_word_i[15:0]`+1 and a 1 gives length `div_word_i[31:16]`+1. For example, nine 0 bits and then ones give nine low-divider halves and then high-divider halves.
- R5: A selected divider of 0 gives a half-period of one system clock cycle.
- R6: Half-period 0 is spent at the idle level. Each even half-period ends in a leading edge, which comes with a one-cycle `sample_o`. Each odd half-period ends in a trailing edge, which comes with a one-cycle `shift_o`. The two strobes are never high together and never high away from an edge.
- R7: Outside a transfer, `sclk_o` follows `cpol_i` with one cycle of delay. With `cpol_i`=1 the leading edge is a falling edge.
- R8: At the clock edge that makes the last trailing edge, `busy_o` falls, `done_o` rises for one cycle and `sclk_o` returns to the idle level.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. The running transfer keeps its timing and no second transfer follows.
- R10: Changes to `pattern_i`, `div_word_i`, `var_en_i` or `master_i` during a transfer do not change its timing.
- R11: When `master_i` is 0, the block runs in fixed mode even if `var_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request strobe |
| master_i | input | 1 | Master mode; must be 1 for variable mode |
| var_en_i | input | 1 | Variable-rate enable |
| cpol_i | input | 1 | Idle level of the serial clock |
| pattern_i | input | 32 | Divider choice per half-period, MSB first |
| div_word_i | input | 32 | Low divider in [15:0], high divider in [31:16] |
| sclk_o | output | 1 | Serial clock |
| sample_o | output | 1 | One-cycle strobe on the leading edge |
| shift_o | output | 1 | One-cycle strobe on the trailing edge |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Most internal faults show up at the next serial clock edge, as a half-period whose length is wrong against the pattern bit it should read. A pattern pointer that is off by one moves the first rate change by a single half-period, so the bench times every edge, not just the total busy length. An edge counter that is wrong in either direction shows up in the cycle where `busy_o` should fall: the fall comes early or late, or `done_o` comes without a matching 32nd edge. Errors in the strobe phase show up within one edge as `sample_o` appearing on a trailing edge.

// File: rtl/spi_varclk_pkg.sv
package spi_varclk_pkg;
  localparam int unsigned DEF_DIV_W  = 16;
  localparam int unsigned DEF_CYCLES = 16;

  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/spi_varclk_cfg.sv
module spi_varclk_cfg #(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned PAT_W       = 32,
  parameter bit          VAR_SUPPORT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               half_end_i,
  input  logic               master_i,
  input  logic               var_en_i,
  input  logic [PAT_W-1:0]   pattern_i,
  input  logic [2*DIV_W-1:0] div_word_i,
  output logic [DIV_W-1:0]   lim_o
);
  logic [DIV_W-1:0] div_lo_q, div_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else if (load_i) begin
      div_lo_q <= div_word_i[DIV_W-1:0];
      div_hi_q <= div_word_i[2*DIV_W-1:DIV_W];
    end
  end

  generate
    if (VAR_SUPPORT) begin : g_var
      logic [PAT_W-1:0] pat_q;
      logic             var_q;

      // pattern shifts left per half-period; MSB is the live selector
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pat_q <= '0;
          var_q <= 1'b0;
        end else if (load_i) begin
          pat_q <= pattern_i;
          var_q <= var_en_i & master_i;
        end else if (half_end_i) begin
          pat_q <= {pat_q[PAT_W-2:0], 1'b0};
        end
      end

      assign lim_o = (var_q && pat_q[PAT_W-1]) ? div_hi_q : div_lo_q;
    end else begin : g_fixed
      logic unused_cfg;
      assign unused_cfg = ^{master_i, var_en_i, pattern_i, div_hi_q, half_end_i};
      assign lim_o      = div_lo_q;
    end
  endgenerate
endmodule

// File: rtl/spi_varclk_timer.sv
module spi_varclk_timer #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             half_end_o
);
  logic [DIV_W-1:0] cnt_q;

  assign half_end_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i || half_end_o)  cnt_q <= '0;
    else if (run_i)                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_varclk_seq.sv
module spi_varclk_seq
  import spi_varclk_pkg::*;
#(
  parameter int unsigned PAT_W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic half_end_i,
  input  logic cpol_i,
  output logic sclk_o,
  output logic sample_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned HALF_W = $clog2(PAT_W);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(PAT_W - 1);

  logic [HALF_W-1:0] half_q;
  logic              sclk_q, sample_q, shift_q, busy_q, done_q;
  edge_kind_e        kind;

  assign kind = edge_kind_e'(half_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q   <= '0;
      sclk_q   <= 1'b0;
      sample_q <= 1'b0;
      shift_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      sample_q <= 1'b0;
      shift_q  <= 1'b0;
      done_q   <= 1'b0;
      if (load_i) begin
        busy_q <= 1'b1;
        half_q <= '0;
        sclk_q <= cpol_i;
      end else if (busy_q) begin
        if (half_end_i) begin
          sclk_q   <= ~sclk_q;
          sample_q <= (kind == EDGE_LEAD);
          shift_q  <= (kind == EDGE_TRAIL);
          half_q   <= half_q + 1'b1;
          if (half_q == LAST_HALF) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        sclk_q <= cpol_i;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign sample_o = sample_q;
  assign shift_o  = shift_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/spi_varclk_gen.sv
module spi_varclk_gen
  import spi_varclk_pkg::*;
#(
  parameter int unsigned DIV_W       = DEF_DIV_W,
  parameter int unsigned CYCLES      = DEF_CYCLES,
  parameter bit          VAR_SUPPORT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  master_i,
  input  logic                  var_en_i,
  input  logic                  cpol_i,
  input  logic [2*CYCLES-1:0]   pattern_i,
  input  logic [2*DIV_W-1:0]    div_word_i,
  output logic                  sclk_o,
  output logic                  sample_o,
  output logic                  shift_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int unsigned PAT_W = 2 * CYCLES;

  logic             load, half_end, busy;
  logic [DIV_W-1:0] lim;

  assign load   = start_i & ~busy;
  assign busy_o = busy;

  spi_varclk_cfg #(
    .DIV_W(DIV_W), .PAT_W(PAT_W), .VAR_SUPPORT(VAR_SUPPORT)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .half_end_i(half_end),
    .master_i(master_i), .var_en_i(var_en_i), .pattern_i(pattern_i),
    .div_word_i(div_word_i), .lim_o(lim)
  );

  spi_varclk_timer #(.DIV_W(DIV_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load), .run_i(busy),
    .lim_i(lim), .half_end_o(half_end)
  );

  spi_varclk_seq #(.PAT_W(PAT_W)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .half_end_i(half_end),
    .cpol_i(cpol_i), .sclk_o(sclk_o), .sample_o(sample_o), .shift_o(shift_o),
    .busy_o(busy), .done_o(done_o)
  );
endmodule

// File: rtl/spi_varclk_chk.sv
module spi_varclk_chk #(
  parameter int unsigned CYCLES = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic sample_o,
  input logic shift_o,
  input logic busy_o,
  input logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES) + 2;

  logic             ready_q;
  logic [CNT_W-1:0] lead_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q    <= 1'b0;
      lead_cnt_q <= '0;
    end else begin
      ready_q <= 1'b1;
      if (start_i && !busy_o) lead_cnt_q <= '0;
      else if (sample_o)      lead_cnt_q <= lead_cnt_q + 1'b1;
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R2
  lead_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_cnt_q <= CNT_W'(CYCLES));
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && shift_o));
  // R6
  strobe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && (sample_o || shift_o)) |-> (sclk_o != $past(sclk_o)));
  // R7
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && !busy_o && !done_o && $past(!busy_o)) |-> (sclk_o == $past(cpol_i)));
  // R8
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
endmodule

bind spi_varclk_gen spi_varclk_chk #(.CYCLES(CYCLES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cpol_i(cpol_i),
  .sclk_o(sclk_o), .sample_o(sample_o), .shift_o(shift_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_spi_varclk_gen.sv
module test_spi_varclk_gen;
  typedef struct packed {
    logic        var_en;
    logic        master;
    logic        cpol;
    logic [31:0] pat;
    logic [31:0] div;
  } vec_t;

  // R3, R4, R5, R7, R11 stimulus
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0003_0001},  // R3 fixed, pattern ignored
    '{1'b1, 1'b1, 1'b0, 32'h007F_FFFF, 32'h0004_0000},  // R4 nine lows then highs
    '{1'b1, 1'b0, 1'b0, 32'hAAAA_AAAA, 32'h0002_0001},  // R11 not master
    '{1'b1, 1'b1, 1'b1, 32'hAAAA_AAAA, 32'h0000_0002},  // R7 cpol=1, alternating
    '{1'b1, 1'b1, 1'b0, 32'h8000_0001, 32'h0005_0000},  // R4 end bits
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0007_0000}   // R5 divider 0
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, master_i = 1'b1, var_en_i = 1'b0, cpol_i = 1'b1;
  logic [31:0] pattern_i = '0, div_word_i = '0;
  logic        sclk_o, sample_o, shift_o, busy_o, done_o;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  spi_varclk_gen i_spi_varclk_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .master_i(master_i),
    .var_en_i(var_en_i), .cpol_i(cpol_i), .pattern_i(pattern_i),
    .div_word_i(div_word_i), .sclk_o(sclk_o), .sample_o(sample_o),
    .shift_o(shift_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_len(input vec_t v, input int h);
    bit sel = v.var_en && v.master && v.pat[31-h];
    return sel ? int'(v.div[31:16]) + 1 : int'(v.div[15:0]) + 1;
  endfunction

  task automatic run_xfer(input vec_t v, input bit disturb);
    int  total = 0, t = 0, last = 0, h = 0, errs = 0, busy_n = 0;
    logic prev;
    for (int i = 0; i < 32; i++) total += half_len(v, i);
    @(negedge clk);
    var_en_i = v.var_en; master_i = v.master; cpol_i = v.cpol;
    pattern_i = v.pat; div_word_i = v.div; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    prev = v.cpol;
    while (1) begin
      if (busy_o) busy_n++;
      if (sclk_o != prev) begin
        if (h < 32 && (t - last) != half_len(v, h)) errs++;
        if (sample_o != (h % 2 == 0) || shift_o != (h % 2 == 1)) errs++;
        last = t; prev = sclk_o; h++;
      end else if (sample_o || shift_o) errs++;
      if (!busy_o || t > 5000) break;
      if (disturb && t == 3) begin  // R9 R10 disturbance
        start_i = 1'b1; pattern_i = ~v.pat; div_word_i = 32'h0006_0006;
        var_en_i = ~v.var_en; master_i = ~v.master;
      end
      if (disturb && t == 4) start_i = 1'b0;
      t++;
      @(negedge clk);
    end
    chk(h == 32, "R2 edge count", h, 32);
    chk(errs == 0, "R3 R4 R5 R6 R11 half lengths and strobes", errs, 0);
    chk(busy_n == total, disturb ? "R10 busy length" : "R3 busy length", busy_n, total);
    chk(done_o == 1'b1 && sclk_o == v.cpol, "R8 done and idle level", {done_o, sclk_o}, {1'b1, v.cpol});
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done single cycle", done_o, 0);
    if (disturb) begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0 && sclk_o == v.cpol, "R9 no second transfer", {busy_o, sclk_o}, {1'b0, v.cpol});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state with cpol_i=1
    chk({sclk_o, sample_o, shift_o, busy_o, done_o} == 5'b0, "R1 reset outputs",
        {sclk_o, sample_o, shift_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sclk_o == 1'b1 && busy_o == 1'b0, "R7 idle follows cpol", {sclk_o, busy_o}, 2);
    cpol_i = 1'b0;
    @(negedge clk);
    chk(sclk_o == 1'b0, "R7 idle follows cpol change", sclk_o, 0);

    for (int i = 0; i < 6; i++) run_xfer(VECS[i], 1'b0);

    // R9 R10: start and config changes mid-transfer
    run_xfer(VECS[1], 1'b1);
    run_xfer(VECS[3], 1'b1);

    // R2 start accepted right after done
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 start after idle", busy_o, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule